// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the two timing strobes that a small 8-bit controller presents to its external memory bus. The first is an address-latch strobe (ALE), which tells an external latch to capture the low address byte. The second is an active-low code-read strobe (PSEN). The block runs on the oscillator clock and divides it into machine cycles of twelve phases. It places two ALE windows and two PSEN windows in each cycle. It also decides, for every code fetch, whether the fetch is served from internal program memory or goes out on the bus.

The core presents the current fetch address and a flag that marks the cycle as an external data-memory access. The sequencer drops strobes in such a data cycle, because the bus is then busy with the data transfer. A mask input limits ALE to data-move cycles, which keeps the pin quiet when no latch is needed. The level on the external-access pin is captured once, when a qualified reset ends, and it then sets the code-address boundary that applies until the next reset. The reset input is filtered: a pulse shorter than two machine cycles leaves the timing state alone, but it still silences the strobes while it is high.

Top module: `strobe_sequencer`

## Requirements
- R1: `phase_o` counts 0 to 11 and wraps to 0. It reads 0 in the first clock after a qualified reset is released.
- R2: ALE is high in phases 0, 1, 6 and 7 in every cycle that is not a data cycle while `ale_mask_i` is 0, whatever the fetch source.
- R3: For an external fetch in a cycle that is not a data cycle, `psen_n_o` is 0 in phases 2, 3, 4, 8, 9 and 10, and 1 in all other phases.
- R4: A cycle is a data cycle when `dmem_req_i` is 1 in phase 0. In a data cycle the ALE pulse at phases 6–7 and both PSEN pulses are omitted, and the ALE pulse at phases 0–1 is kept.
- R5: While `ale_mask_i` is 1, ALE stays low in every cycle that is not a data cycle. In a data cycle the ALE pulse at phases 0–1 still fires.
- R6: `ext_fetch_o` equals 1 when the captured access level is 0, or when `fetch_addr_i` is above 0x0FFF. `psen_n_o` never goes low while `ext_fetch_o` is 0.
- R7: The level on `ea_i` is captured when a qualified reset is released. Changes on `ea_i` after that do not change `ext_fetch_o`.
- R8: A reset takes effect only after `rst_i` has been high on 24 consecutive clock edges. A shorter pulse leaves the phase count running and does not capture a new `ea_i` level.
- R9: While `rst_i` is high, ALE is 0 and `psen_n_o` is 1.
- R10: ALE high and `psen_n_o` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, one phase per period |
| rst_i | input | 1 | Active-high reset request, filtered to 24 clocks |
| ea_i | input | 1 | External-access level, captured at reset release |
| fetch_addr_i | input | 16 | Address of the current code fetch |
| dmem_req_i | input | 1 | Marks the current machine cycle as an external data access |
| ale_mask_i | input | 1 | Limits ALE to data-access cycles |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Code-read strobe, active low |
| phase_o | output | 4 | Current phase within the machine cycle |
| ext_fetch_o | output | 1 | 1 when the current fetch goes to external memory |

## Verification
The main overlap to cover is a data cycle that falls while `ale_mask_i` is set and the fetch address is above the internal boundary. In that cycle, skipping, masking and PSEN routing all act on the same strobe windows. The bench sweeps every combination of captured access level, four addresses on both sides of the 0x0FFF boundary, the data flag and the mask. In each combination it checks ALE and PSEN against windows computed from the phase number. It also applies reset pulses of 23 edges in the middle of a run, which checks that strobes go silent while the phase count keeps running and the captured access level is kept.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  localparam int PHASES_DEF   = 12;
  localparam int ALE_LEN_DEF  = 2;
  localparam int PSEN_LEN_DEF = 3;
  localparam int RST_CYC_DEF  = 24;
  localparam int ADDR_W_DEF   = 16;

  typedef struct packed {
    logic ale;
    logic psen_n;
  } strobe_t;
endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int RST_CYCLES = 24
) (
  input  logic clk,
  input  logic rst_i,
  output logic rst_q
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CYCLES);
  localparam logic [CW-1:0] ARM = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_i)          cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
    rst_q <= rst_i && (cnt >= ARM);
  end

  // R8: a qualified reset only appears after the request was high on the prior edge
  assert_rst_needs_req_R8: assert property (@(posedge clk)
    $rose(rst_q) |-> $past(rst_i));
endmodule

// File: rtl/mc_phase.sv
module mc_phase #(
  parameter int PHASES = 12,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          dmem_req_i,
  output logic [PW-1:0] phase_o,
  output logic          dacc_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;
  logic          dacc_q;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      phase_q <= '0;
      dacc_q  <= 1'b0;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (phase_q == '0) dacc_q <= dmem_req_i;
    end
  end

  assign phase_o = phase_q;
  assign dacc_o  = (phase_q == '0) ? dmem_req_i : dacc_q;

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst_q)
    (phase_q == LAST) |=> (phase_q == '0));
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst_q)
    (phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/fetch_route.sv
module fetch_route #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 'h0FFF
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              rst_q,
  input  logic              ea_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ext_o
);
  logic ea_q;

  always_ff @(posedge clk) begin
    if (rst_q) ea_q <= ea_i;
  end

  assign ext_o = !ea_q || (addr_i > INT_LIMIT);

  // R7: captured level holds once the qualified reset is gone
  assert_ea_hold_R7: assert property (@(posedge clk) disable iff (rst_q || rst_i)
    $past(!rst_q) |-> $stable(ea_q));
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import strobe_seq_pkg::*;
#(
  parameter int PHASES   = 12,
  parameter int ALE_LEN  = 2,
  parameter int PSEN_LEN = 3,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_i,
  input  logic          rst_q,
  input  logic [PW-1:0] phase_i,
  input  logic          dacc_i,
  input  logic          ale_mask_i,
  input  logic          ext_i,
  output logic          ale_o,
  output logic          psen_n_o
);
  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] HALF_P = PW'(HALF);

  logic [1:0] ale_win, psen_win;
  strobe_t    st;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_half
      localparam logic [PW-1:0] A_LO = PW'(g * HALF);
      localparam logic [PW-1:0] A_HI = PW'(g * HALF + ALE_LEN);
      localparam logic [PW-1:0] P_HI = PW'(g * HALF + ALE_LEN + PSEN_LEN);
      assign ale_win[g]  = (phase_i >= A_LO) && (phase_i < A_HI);
      assign psen_win[g] = (phase_i >= A_HI) && (phase_i < P_HI);
    end
  endgenerate

  logic quiet;
  assign quiet = rst_i || rst_q;

  always_comb begin
    st.ale    = 1'b0;
    st.psen_n = 1'b1;
    if (!quiet) begin
      st.ale    = (ale_win[0] && (!ale_mask_i || dacc_i)) ||
                  (ale_win[1] && !ale_mask_i && !dacc_i);
      st.psen_n = !(ext_i && !dacc_i && (psen_win[0] || psen_win[1]));
    end
  end

  assign ale_o    = st.ale;
  assign psen_n_o = st.psen_n;

  assert_rst_silent_R9: assert property (@(posedge clk)
    rst_i |-> (!ale_o && psen_n_o));
  assert_no_overlap_R10: assert property (@(posedge clk)
    !(ale_o && !psen_n_o));
  assert_internal_no_psen_R6: assert property (@(posedge clk)
    !ext_i |-> psen_n_o);
  assert_data_skip_R4: assert property (@(posedge clk) disable iff (quiet)
    (dacc_i && phase_i == HALF_P) |-> !ale_o);
endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
  import strobe_seq_pkg::*;
#(
  parameter int PHASES     = PHASES_DEF,
  parameter int ALE_LEN    = ALE_LEN_DEF,
  parameter int PSEN_LEN   = PSEN_LEN_DEF,
  parameter int RST_CYCLES = RST_CYC_DEF,
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] INT_LIMIT = 'h0FFF,
  localparam int PW = $clog2(PHASES)
) (
  input  logic              clk_osc,
  input  logic              rst_i,
  input  logic              ea_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              dmem_req_i,
  input  logic              ale_mask_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic [PW-1:0]     phase_o,
  output logic              ext_fetch_o
);
  logic          rst_q;
  logic          dacc;
  logic [PW-1:0] phase;

  rst_qualifier #(.RST_CYCLES(RST_CYCLES)) u_rstq (
    .clk(clk_osc), .rst_i(rst_i), .rst_q(rst_q));

  mc_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk_osc), .rst_q(rst_q), .dmem_req_i(dmem_req_i),
    .phase_o(phase), .dacc_o(dacc));

  fetch_route #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_route (
    .clk(clk_osc), .rst_i(rst_i), .rst_q(rst_q), .ea_i(ea_i),
    .addr_i(fetch_addr_i), .ext_o(ext_fetch_o));

  strobe_gen #(.PHASES(PHASES), .ALE_LEN(ALE_LEN), .PSEN_LEN(PSEN_LEN)) u_gen (
    .clk(clk_osc), .rst_i(rst_i), .rst_q(rst_q), .phase_i(phase),
    .dacc_i(dacc), .ale_mask_i(ale_mask_i), .ext_i(ext_fetch_o),
    .ale_o(ale_o), .psen_n_o(psen_n_o));

  assign phase_o = phase;
endmodule

// File: tb/strobe_sequencer_bench.sv
module strobe_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ea = 1'b1;
  logic [15:0] addr = '0;
  logic        dm = 1'b0;
  logic        amask = 1'b0;
  logic        ale, psen_n, ext;
  logic [3:0]  phase;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit ea_lat = 1'b1;
  logic [15:0] addrs [4] = '{16'h0000, 16'h0FFF, 16'h1000, 16'hFFFF};

  always #5 clk = ~clk;

  strobe_sequencer u_strobe_sequencer (
    .clk_osc(clk), .rst_i(rst), .ea_i(ea), .fetch_addr_i(addr),
    .dmem_req_i(dm), .ale_mask_i(amask), .ale_o(ale), .psen_n_o(psen_n),
    .phase_o(phase), .ext_fetch_o(ext));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic full_reset(input bit lvl);
    @(negedge clk);
    rst = 1'b1; ea = lvl; dm = 1'b0; amask = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk(ale == 1'b0, "R9 ale in reset", int'(ale), 0);
      chk(psen_n == 1'b1, "R9 psen in reset", int'(psen_n), 1);
    end
    rst = 1'b0;
    ea_lat = lvl;
    ph = 11;
  endtask

  // Caller stands at the negedge where the logical phase is 11.
  task automatic run_cycle(input logic [15:0] a, input bit d, input bit m);
    bit x;
    addr = a; dm = d; amask = m;
    x = !ea_lat || (a > 16'h0FFF);
    for (int p = 0; p < 12; p++) begin
      bit ea_exp, ps_exp;
      @(negedge clk);
      ph = p;
      if (p < 2)                ea_exp = !m || d;
      else if (p >= 6 && p < 8) ea_exp = !m && !d;
      else                      ea_exp = 1'b0;
      ps_exp = !(x && !d && ((p >= 2 && p < 5) || (p >= 8 && p < 11)));
      chk(phase == 4'(p), "R1 phase", int'(phase), p);
      chk(ale == ea_exp, (m && !d) ? "R5 ale masked" : (d ? "R4 ale data" : "R2 ale"),
          int'(ale), int'(ea_exp));
      chk(psen_n == ps_exp, !x ? "R6 psen internal" : (d ? "R4 psen data" : "R3 psen"),
          int'(psen_n), int'(ps_exp));
      chk(ext == x, (ea != ea_lat) ? "R7 ext after ea change" : "R6 ext",
          int'(ext), int'(x));
      chk(!(ale && !psen_n), "R10 overlap", int'(ale), 0);
    end
  endtask

  task automatic short_pulse(input int n);
    @(negedge clk);
    ph = (ph + 1) % 12;
    rst = 1'b1;
    ea = ~ea;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ph = (ph + 1) % 12;
      chk(phase == 4'(ph), "R8 phase runs through short reset", int'(phase), ph);
      chk(ale == 1'b0 && psen_n == 1'b1, "R9 silent during short reset",
          int'({ale, psen_n}), 1);
    end
    rst = 1'b0;
    while (ph != 11) begin
      @(negedge clk);
      ph = ph + 1;
      chk(phase == 4'(ph), "R8 phase after short reset", int'(phase), ph);
    end
  endtask

  initial begin
    for (int e = 0; e < 2; e++) begin
      full_reset(e[0]);
      run_cycle(16'h0100, 1'b0, 1'b0);
      ea = ~ea;
      for (int ai = 0; ai < 4; ai++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 2; m++)
            run_cycle(addrs[ai], d[0], m[0]);
      short_pulse(23);
      run_cycle(16'h0800, 1'b0, 1'b0);
      run_cycle(16'h1000, 1'b1, 1'b1);
      run_cycle(16'h0FFF, 1'b1, 1'b0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule